// File: doc/BRIEF.md
# Two-Row Gradient Magnitude Unit

This unit computes edge strength over a stream of column pairs taken from two vertically adjacent rows of a smoothed image. Each accepted beat delivers one column: an upper-row pixel and a lower-row pixel, both unsigned 16-bit values. From every pair of horizontally neighbouring columns it forms a 2x2 window.

The unit applies a horizontal derivative kernel (left column negative, right column positive) and a vertical derivative kernel (upper row negative, lower row positive). It then adds the absolute values of the two responses.

The unit keeps the sum and the difference of the most recent column in registers. Each new column therefore needs only its own sum and its own lower-minus-upper difference. A line-end flag marks the last column of a line, and the next accepted column starts a fresh window.

Top module: `gradmag2x2`

## Requirements
- R1: Let the left column be upper a, lower c, and the right column be upper b, lower d, all unsigned 16-bit. The result is |(b+d)-(a+c)| + |(c+d)-(a+b)|. `inTop` carries the upper row and `inBot` carries the lower row. Columns arrive left to right.
- R2: The first accepted column of a line produces no result. The first beat after reset is the first column of a line.
- R3: A result is presented on `outMag` with `outValid` high exactly two clock cycles after the rising edge that accepted its right-hand column.
- R4: Every accepted column after the first in a line produces exactly one result, in arrival order.
- R5: A beat accepted with `inLast` high still produces its own result, unless it is the first column of its line. The next accepted column begins a new line, which forms no window with the old one.
- R6: When the true magnitude exceeds 65535, `outMag` reads 65535.
- R7: Cycles with `inValid` low are ignored. They change no stored column, they produce no result, and they do not break a window between the accepted columns on either side of them.
- R8: While reset is high, and after it, until the first result, `outValid` is 0 and `outMag` is 0. Between results, `outMag` holds its last value.
- R9: A window whose four pixels are all equal yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Column beat present |
| inTop | input | 16 | Upper-row pixel, unsigned |
| inBot | input | 16 | Lower-row pixel, unsigned |
| inLast | input | 1 | This beat is the last column of its line |
| outValid | output | 1 | Result present |
| outMag | output | 16 | Saturated L1 gradient magnitude |

## Verification
A ramp that rises along the row and down the column makes both kernel responses non-zero and of different sizes. This separates a correct combination from one that uses only one kernel or swaps the rows. Alternating extreme columns drive both responses to full scale, so saturation and the sign handling of the absolute values are exercised. Idle gaps inside a line and line-end flags in mid-stream show whether the stored column survives idle cycles and is dropped at a line boundary. A uniform patch shows that equal pixels cancel.

// File: rtl/gradmag_pkg.sv
package gradmag_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // store the incoming column as the new left column
    logic pairOk;   // a full window exists: register both kernel responses
    logic magLoad;  // stage-two result update
  } gmStrobe_t;
endpackage

// File: rtl/gm_ctrl.sv
module gm_ctrl
  import gradmag_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      inLast,
  output gmStrobe_t strobe,
  output logic      outValid
);
  logic haveCol;
  logic s1Valid;

  always_comb begin
    strobe.capture = inValid;
    strobe.pairOk  = inValid & haveCol;
    strobe.magLoad = s1Valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      haveCol  <= 1'b0;
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (inValid) haveCol <= ~inLast;
      s1Valid  <= strobe.pairOk;
      outValid <= s1Valid;
    end
  end
endmodule

// File: rtl/gm_datapath.sv
module gm_datapath
  import gradmag_pkg::*;
#(
  parameter int PIX_W = 16,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  gmStrobe_t        strobe,
  input  logic [PIX_W-1:0] inTop,
  input  logic [PIX_W-1:0] inBot,
  output logic [OUT_W-1:0] outMag
);
  localparam int SUM_W = PIX_W + 1;
  localparam int DIF_W = PIX_W + 2;
  localparam int MAG_W = PIX_W + 3;

  logic        [SUM_W-1:0] colSum, prevSum;
  logic signed [SUM_W-1:0] colDiff, prevDiff;
  logic signed [DIF_W-1:0] horizNext, vertNext, horiz, vert;
  logic        [DIF_W-1:0] absH, absV;
  logic        [MAG_W-1:0] magSum;
  logic        [OUT_W-1:0] satMag;

  // stage one: new column sum/difference against the stored column
  always_comb begin
    colSum    = {1'b0, inTop} + {1'b0, inBot};
    colDiff   = $signed({1'b0, inBot}) - $signed({1'b0, inTop});
    horizNext = $signed({1'b0, colSum}) - $signed({1'b0, prevSum});
    vertNext  = $signed({colDiff[SUM_W-1], colDiff}) + $signed({prevDiff[SUM_W-1], prevDiff});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevSum  <= '0;
      prevDiff <= '0;
      horiz    <= '0;
      vert     <= '0;
    end else begin
      if (strobe.capture) begin
        prevSum  <= colSum;
        prevDiff <= colDiff;
      end
      if (strobe.pairOk) begin
        horiz <= horizNext;
        vert  <= vertNext;
      end
    end
  end

  // stage two: absolute values, final add, saturation
  always_comb begin
    absH   = horiz[DIF_W-1] ? DIF_W'(-horiz) : DIF_W'(horiz);
    absV   = vert[DIF_W-1]  ? DIF_W'(-vert)  : DIF_W'(vert);
    magSum = {1'b0, absH} + {1'b0, absV};
  end

  generate
    if (OUT_W < MAG_W) begin : g_sat
      assign satMag = (|magSum[MAG_W-1:OUT_W]) ? {OUT_W{1'b1}} : magSum[OUT_W-1:0];
    end else if (OUT_W == MAG_W) begin : g_same
      assign satMag = magSum;
    end else begin : g_pad
      assign satMag = {{(OUT_W-MAG_W){1'b0}}, magSum};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                 outMag <= '0;
    else if (strobe.magLoad) outMag <= satMag;
  end
endmodule

// File: rtl/gradmag2x2.sv
module gradmag2x2
  import gradmag_pkg::*;
#(
  parameter int PIX_W = 16,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [PIX_W-1:0] inTop,
  input  logic [PIX_W-1:0] inBot,
  input  logic             inLast,
  output logic             outValid,
  output logic [OUT_W-1:0] outMag
);
  gmStrobe_t strobe;

  gm_ctrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast),
    .strobe(strobe), .outValid(outValid)
  );

  gm_datapath #(.PIX_W(PIX_W), .OUT_W(OUT_W)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .inTop(inTop), .inBot(inBot), .outMag(outMag)
  );
endmodule

// File: rtl/gm_checker.sv
module gm_checker #(
  parameter int PIX_W = 16,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [PIX_W-1:0] inTop,
  input logic [PIX_W-1:0] inBot,
  input logic             inLast,
  input logic             outValid,
  input logic [OUT_W-1:0] outMag
);
  logic             seenCol;
  logic [PIX_W-1:0] lastTop, lastBot;

  always_ff @(posedge clk) begin
    if (rst) begin
      seenCol <= 1'b0;
      lastTop <= '0;
      lastBot <= '0;
    end else if (inValid) begin
      seenCol <= ~inLast;
      lastTop <= inTop;
      lastBot <= inBot;
    end
  end

  // R2
  first_col_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !seenCol) |=> ##1 !outValid);

  // R4
  pair_emits_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && seenCol) |=> ##1 outValid);

  // R3
  latency_src_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 2));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outMag));

  // R9
  flat_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && seenCol && inTop == lastTop && inBot == lastBot && inTop == inBot)
      |=> ##1 (outValid && outMag == '0));
endmodule

bind gradmag2x2 gm_checker #(.PIX_W(PIX_W), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .inTop(inTop), .inBot(inBot),
  .inLast(inLast), .outValid(outValid), .outMag(outMag)
);

// File: tb/gradmag2x2_tb_top.sv
module gradmag2x2_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [15:0] inTop, inBot;
  logic        inLast;
  logic        outValid;
  logic [15:0] outMag;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  string curReq = "R1";

  always #10 clk = ~clk;  // 50 MHz

  gradmag2x2 dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inTop(inTop), .inBot(inBot),
    .inLast(inLast), .outValid(outValid), .outMag(outMag)
  );

  // direct 2x2 convolution model
  function automatic int conv(int a, int b, int c, int d);
    int h, v, m;
    h = (b + d) - (a + c);
    v = (c + d) - (a + b);
    m = (h < 0 ? -h : h) + (v < 0 ? -v : v);
    return (m > 65535) ? 65535 : m;
  endfunction

  logic haveL;
  int   pT, pB;
  logic eV1, eV2;
  int   eM1, eM2;
  int   lastOut;

  always @(posedge clk) begin
    if (rst) begin
      haveL <= 1'b0; pT <= 0; pB <= 0;
      eV1 <= 1'b0; eV2 <= 1'b0; eM1 <= 0; eM2 <= 0;
    end else begin
      eV2 <= eV1; eM2 <= eM1;
      eV1 <= inValid && haveL;
      eM1 <= conv(pT, inTop, pB, inBot);
      if (inValid) begin
        haveL <= !inLast;
        pT <= inTop; pB <= inBot;
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst) lastOut = 0;
    else begin
      checks++;
      if (outValid !== eV2) begin
        errors++;
        $display("FAIL %s/R3 outValid actual=%0b expected=%0b", curReq, outValid, eV2);
      end else if (eV2) begin
        checks++;
        if (int'(outMag) != eM2) begin
          errors++;
          $display("FAIL %s outMag actual=%0d expected=%0d", curReq, outMag, eM2);
        end
        lastOut = eM2;
      end else begin
        checks++;
        if (int'(outMag) != lastOut) begin
          errors++;
          $display("FAIL R8 hold outMag actual=%0d expected=%0d", outMag, lastOut);
        end
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic beat(input int t, input int b, input bit last);
    @(negedge clk);
    inValid = 1'b1; inTop = 16'(t); inBot = 16'(b); inLast = last;
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic streamBeat(input int t, input int b, input bit last);
    @(negedge clk);
    inValid = 1'b1; inTop = 16'(t); inBot = 16'(b); inLast = last;
  endtask

  task automatic t_reset();  // R8
    rst = 1'b1; inValid = 1'b0; inTop = '0; inBot = '0; inLast = 1'b0;
    idle(3);
    checks++;
    if (outValid !== 1'b0 || outMag !== 16'd0) begin
      errors++;
      $display("FAIL R8 reset actual=%0b/%0d expected=0/0", outValid, outMag);
    end
    @(negedge clk); rst = 1'b0;
    idle(2);
  endtask

  task automatic t_first_col();  // R2
    curReq = "R2";
    beat(100, 300, 1'b0);
    idle(3);
    beat(900, 50, 1'b1);
    idle(3);
  endtask

  task automatic t_ramp();  // R1, R4 back-to-back
    curReq = "R1";
    for (int i = 0; i < 12; i++) streamBeat(1000 + 37*i, 5000 + 11*i*i, i == 11);
    @(negedge clk); inValid = 1'b0; inLast = 1'b0;
    curReq = "R4";
    for (int i = 0; i < 8; i++) streamBeat(60000 - 900*i, 200 + 1500*i, i == 7);
    @(negedge clk); inValid = 1'b0; inLast = 1'b0;
    idle(3);
  endtask

  task automatic t_line_end();  // R5
    curReq = "R5";
    streamBeat(10, 20, 1'b0);
    streamBeat(40, 5, 1'b1);
    streamBeat(7000, 9000, 1'b0);
    streamBeat(3000, 100, 1'b0);
    streamBeat(50, 60000, 1'b1);
    @(negedge clk); inValid = 1'b0; inLast = 1'b0;
    idle(3);
  endtask

  task automatic t_saturate();  // R6
    curReq = "R6";
    streamBeat(0, 65535, 1'b0);
    streamBeat(65535, 65535, 1'b0);
    streamBeat(0, 0, 1'b0);
    streamBeat(65535, 65535, 1'b0);
    streamBeat(65535, 0, 1'b1);
    @(negedge clk); inValid = 1'b0; inLast = 1'b0;
    idle(3);
    checks++;
    if (outMag !== 16'hFFFF) begin  // last window: a=65535,c=65535,b=65535,d=0 -> 131070
      errors++;
      $display("FAIL R6 outMag actual=%0d expected=65535", outMag);
    end
  endtask

  task automatic t_gaps();  // R7
    curReq = "R7";
    beat(1200, 3400, 1'b0);
    idle(4);
    beat(5600, 700, 1'b0);
    idle(1);
    beat(20, 40000, 1'b1);
    idle(4);
  endtask

  task automatic t_flat();  // R9
    curReq = "R9";
    streamBeat(4321, 4321, 1'b0);
    streamBeat(4321, 4321, 1'b0);
    streamBeat(4321, 4321, 1'b1);
    @(negedge clk); inValid = 1'b0; inLast = 1'b0;
    idle(3);
    checks++;
    if (outMag !== 16'd0) begin
      errors++;
      $display("FAIL R9 outMag actual=%0d expected=0", outMag);
    end
  endtask

  initial begin
    t_reset();
    t_first_col();
    t_ramp();
    t_line_end();
    t_saturate();
    t_gaps();
    t_flat();
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule